// File: doc/BRIEF.md
# Credit-Based Burst Segmentation Scheduler

This block decides when packet data leaves an upstream word FIFO and how it is cut into bursts for a framed-link transmitter. Flow control is counted in credits. One credit covers 2^WPC_LOG words, which is 8 two-byte words (16 bytes) by default. A static setting caps a burst at a number of credits. A static mode bit picks one of two policies. In whole-burst mode a burst is sent only when it can run to the full cap, or when it ends on an end-of-packet inside that cap. In segment mode a burst may stop at any credit boundary.

The FIFO reports two counts. The first is how many words it holds. The second is how many words lead up to and include the first buffered end-of-packet, or zero when none is buffered. Credits arrive as a per-cycle increment. While idle, the scheduler plans the whole burst in one cycle and charges its credits at that moment. It then pops the planned number of words on consecutive cycles. The start strobe is on the first popped word and the end strobe is on the last.

Top module: `burst_sched`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_en`, `burst_start` and `burst_end` are low. The credit balance restarts at zero.
- R2: A burst pops its planned word count on consecutive cycles of `rd_en`. `burst_start` is high only on the first of those cycles and `burst_end` only on the last. A one-word burst carries both strobes in the same cycle.
- R3: In whole-burst mode (`cfg_segment`=0), a burst that is not ended by a packet end holds exactly cap×8 words. It starts only once `fifo_words` ≥ cap×8 and the balance is at least the cap.
- R4: In whole-burst mode, when `eop_words` is nonzero and at most cap×8, the burst is exactly `eop_words` long. It starts once the balance covers ceil(`eop_words`/8) credits.
- R5: In segment mode (`cfg_segment`=1) with no usable packet end, the burst is n×8 words, where n is the smallest of the cap, the credit balance and floor(`fifo_words`/8). No burst starts while n is 0.
- R6: In segment mode, when ceil(`eop_words`/8) is nonzero and no larger than min(cap, balance), the burst is exactly `eop_words` long.
- R7: Each burst takes ceil(words/8) credits from the balance in its planning cycle, so a partial last credit costs a whole credit. `credit_add` is added every cycle. When an add and a take fall in the same cycle, both take effect. With too few credits, nothing is popped.
- R8: A `cfg_burst_len` of 0 behaves as a cap of 1 credit.
- R9: After each burst end there is at least one cycle with `rd_en` low before the next `burst_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | LEN_W | Burst cap in credits (static, 1..63; 0 acts as 1) |
| cfg_segment | input | 1 | Static policy: 0 whole bursts, 1 close at any credit boundary |
| fifo_words | input | CNT_W | Words currently held in the upstream FIFO |
| eop_words | input | CNT_W | Words up to and including the first buffered packet end, 0 if none |
| credit_add | input | CREDIT_W | Credits granted this cycle |
| rd_en | output | 1 | Data-valid strobe: pop one FIFO word this cycle |
| burst_start | output | 1 | First word of a burst |
| burst_end | output | 1 | Last word of a burst |

## Verification
The collision that matters is a credit grant on the same cycle that a burst is planned and its credits are charged. The bench makes it happen by pushing data and pulsing `credit_add` on the same falling edge while one credit is banked. The planning edge then sees both events. Only the combined balance, one taken and three added, yields the bench's expected follow-up burst lengths (16 words, then 8, then silence). A lost add or a lost take shows up as a missing or over-long burst in the scoreboard.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;

  typedef enum logic {
    MODE_WHOLE   = 1'b0,
    MODE_SEGMENT = 1'b1
  } burst_mode_e;

endpackage

// File: rtl/bsp_planner.sv
module bsp_planner
  import burst_sched_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int LEN_W    = 6,
  parameter int CREDIT_W = 10,
  parameter int WPC_LOG  = 3,
  localparam int BURST_W = LEN_W + WPC_LOG,
  localparam int WW      = CNT_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LEN_W-1:0]    cfg_len,
  input  burst_mode_e         mode,
  input  logic [CNT_W-1:0]    fifo_words,
  input  logic [CNT_W-1:0]    eop_words,
  input  logic [CREDIT_W-1:0] credit_q,
  output logic                go,
  output logic [BURST_W-1:0]  plan_words,
  output logic [LEN_W-1:0]    plan_credits
);

  localparam int WPC = 1 << WPC_LOG;

  logic [LEN_W-1:0] len_eff;
  logic [WW-1:0]    len_w, lim_words, eop_ext, fifo_ext, eop_cr, whole_cr;
  logic [WW-1:0]    credit_w, aff_w, n_w;
  logic             has_eop;

  always_comb begin
    len_eff   = (cfg_len == '0) ? LEN_W'(1) : cfg_len;
    len_w     = WW'(len_eff);
    lim_words = len_w << WPC_LOG;
    eop_ext   = WW'(eop_words);
    fifo_ext  = WW'(fifo_words);
    eop_cr    = (eop_ext + WW'(WPC - 1)) >> WPC_LOG;
    whole_cr  = fifo_ext >> WPC_LOG;
    credit_w  = WW'(credit_q);
    aff_w     = (credit_w >= len_w) ? len_w : credit_w;
    has_eop   = (eop_ext != '0);
    n_w       = (aff_w < whole_cr) ? aff_w : whole_cr;
  end

  always_comb begin
    go           = 1'b0;
    plan_words   = '0;
    plan_credits = '0;
    if (mode == MODE_WHOLE) begin
      if (has_eop && eop_ext <= lim_words) begin
        go           = (credit_w >= eop_cr);
        plan_words   = BURST_W'(eop_ext);
        plan_credits = LEN_W'(eop_cr);
      end else begin
        go           = (fifo_ext >= lim_words) && (credit_w >= len_w);
        plan_words   = BURST_W'(lim_words);
        plan_credits = len_eff;
      end
    end else begin
      if (has_eop && eop_cr <= aff_w) begin
        go           = 1'b1;
        plan_words   = BURST_W'(eop_ext);
        plan_credits = LEN_W'(eop_cr);
      end else begin
        go           = (n_w != '0);
        plan_words   = BURST_W'(n_w << WPC_LOG);
        plan_credits = LEN_W'(n_w);
      end
    end
  end

  // R5: a planned burst never exceeds the configured cap
  p_cap_bound_r5: assert property (@(posedge clk) disable iff (rst)
    go |-> (WW'(plan_credits) <= WW'(len_eff)));

  // R7: a planned burst never asks for more credits than are banked
  p_credit_cover_r7: assert property (@(posedge clk) disable iff (rst)
    go |-> (WW'(plan_credits) <= WW'(credit_q)));

  // R4: a packet-end burst in whole mode never passes the packet end
  p_eop_limit_r4: assert property (@(posedge clk) disable iff (rst)
    (go && mode == MODE_WHOLE && has_eop) |-> (WW'(plan_words) <= eop_ext));

endmodule

// File: rtl/bsp_credits.sv
module bsp_credits #(
  parameter int LEN_W    = 6,
  parameter int CREDIT_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take_en,
  input  logic [LEN_W-1:0]    take_amt,
  input  logic [CREDIT_W-1:0] add,
  output logic [CREDIT_W-1:0] credit_q
);

  localparam int SW = CREDIT_W + 1;
  localparam logic [SW-1:0] MAXV = SW'({CREDIT_W{1'b1}});

  logic [SW-1:0] after_take, sum;

  always_comb begin
    after_take = SW'(credit_q) - (take_en ? SW'(take_amt) : '0);
    sum        = after_take + SW'(add);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q <= '0;
    end else begin
      credit_q <= (sum > MAXV) ? CREDIT_W'(MAXV) : CREDIT_W'(sum);
    end
  end

  // R7: a take is always covered by the banked balance
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    take_en |-> (SW'(take_amt) <= SW'(credit_q)));

  // R7: with no take and no add the balance holds
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!take_en && add == '0) |=> $stable(credit_q));

endmodule

// File: rtl/bsp_seq.sv
module bsp_seq #(
  parameter int BURST_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [BURST_W-1:0] plan_words,
  output logic               launch,
  output logic               rd_en,
  output logic               burst_start,
  output logic               burst_end
);

  logic [BURST_W-1:0] remain_q;

  assign launch = go && !rd_en && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en       <= 1'b0;
      burst_start <= 1'b0;
      burst_end   <= 1'b0;
      remain_q    <= '0;
    end else if (!rd_en) begin
      if (go) begin
        rd_en       <= 1'b1;
        burst_start <= 1'b1;
        burst_end   <= (plan_words == BURST_W'(1));
        remain_q    <= plan_words - BURST_W'(1);
      end else begin
        burst_start <= 1'b0;
        burst_end   <= 1'b0;
      end
    end else if (burst_end) begin
      rd_en       <= 1'b0;
      burst_start <= 1'b0;
      burst_end   <= 1'b0;
    end else begin
      burst_start <= 1'b0;
      burst_end   <= (remain_q == BURST_W'(1));
      remain_q    <= remain_q - BURST_W'(1);
    end
  end

  // R2: strobes only accompany popped words
  p_start_valid_r2: assert property (@(posedge clk) disable iff (rst)
    burst_start |-> rd_en);
  p_end_valid_r2: assert property (@(posedge clk) disable iff (rst)
    burst_end |-> rd_en);

  // R2: a burst runs on without gaps or a second start until its end
  p_continuous_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !burst_end) |=> (rd_en && !burst_start));

  // R9: a burst end is followed by an idle cycle
  p_gap_after_end_r9: assert property (@(posedge clk) disable iff (rst)
    burst_end |=> !rd_en);

  // R2: a launched plan is never empty
  p_plan_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    launch |-> (plan_words != '0));

endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import burst_sched_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int LEN_W    = 6,
  parameter int CREDIT_W = 10,
  parameter int WPC_LOG  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LEN_W-1:0]    cfg_burst_len,
  input  logic                cfg_segment,
  input  logic [CNT_W-1:0]    fifo_words,
  input  logic [CNT_W-1:0]    eop_words,
  input  logic [CREDIT_W-1:0] credit_add,
  output logic                rd_en,
  output logic                burst_start,
  output logic                burst_end
);

  localparam int BURST_W = LEN_W + WPC_LOG;

  burst_mode_e         mode;
  logic                go, launch;
  logic [BURST_W-1:0]  plan_words;
  logic [LEN_W-1:0]    plan_credits;
  logic [CREDIT_W-1:0] credit_q;

  assign mode = cfg_segment ? MODE_SEGMENT : MODE_WHOLE;

  bsp_planner #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .CREDIT_W(CREDIT_W), .WPC_LOG(WPC_LOG)
  ) u_plan (
    .clk(clk), .rst(rst), .cfg_len(cfg_burst_len), .mode(mode),
    .fifo_words(fifo_words), .eop_words(eop_words), .credit_q(credit_q),
    .go(go), .plan_words(plan_words), .plan_credits(plan_credits)
  );

  bsp_credits #(
    .LEN_W(LEN_W), .CREDIT_W(CREDIT_W)
  ) u_cred (
    .clk(clk), .rst(rst), .take_en(launch), .take_amt(plan_credits),
    .add(credit_add), .credit_q(credit_q)
  );

  bsp_seq #(
    .BURST_W(BURST_W)
  ) u_seq (
    .clk(clk), .rst(rst), .go(go), .plan_words(plan_words),
    .launch(launch), .rd_en(rd_en), .burst_start(burst_start),
    .burst_end(burst_end)
  );

  // R1: the cycle after reset is idle
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rd_en && !burst_start && !burst_end));

endmodule

// File: tb/burst_sched_test.sv
module burst_sched_test;

  localparam int CNT_W = 12, LEN_W = 6, CREDIT_W = 10, DEPTH = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LEN_W-1:0]    cfg_burst_len = 6'd2;
  logic                cfg_segment = 1'b0;
  logic [CNT_W-1:0]    fifo_words;
  logic [CNT_W-1:0]    eop_words;
  logic [CREDIT_W-1:0] credit_add = '0;
  logic rd_en, burst_start, burst_end;

  always #4 clk = ~clk;

  burst_sched #(.CNT_W(CNT_W), .LEN_W(LEN_W), .CREDIT_W(CREDIT_W)) uut (
    .clk(clk), .rst(rst), .cfg_burst_len(cfg_burst_len),
    .cfg_segment(cfg_segment), .fifo_words(fifo_words),
    .eop_words(eop_words), .credit_add(credit_add), .rd_en(rd_en),
    .burst_start(burst_start), .burst_end(burst_end)
  );

  // FIFO model
  bit eop_mem [DEPTH];
  int wr_cnt = 0;
  int rd_cnt = 0;

  always @(posedge clk) if (rd_en) rd_cnt <= rd_cnt + 1;

  always_comb begin
    int occ;
    bit found;
    occ = wr_cnt - rd_cnt;
    found = 1'b0;
    eop_words = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && i < occ && eop_mem[(rd_cnt + i) % DEPTH]) begin
        found = 1'b1;
        eop_words = CNT_W'(i + 1);
      end
    end
    fifo_words = CNT_W'(occ);
  end

  int checks = 0;
  int errors = 0;
  int exp_len[$];
  string exp_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_burst(input int len, input string tag);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
  endtask

  task automatic push_pkt(input int n, input bit eop);
    for (int i = 0; i < n; i++)
      eop_mem[(wr_cnt + i) % DEPTH] = eop && (i == n - 1);
    wr_cnt = wr_cnt + n;
  endtask

  task automatic add_credit(input int n);
    credit_add = CREDIT_W'(n);
    @(negedge clk);
    credit_add = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_quiet(input string tag);
    check(exp_len.size() == 0, tag, "pending bursts", exp_len.size(), 0);
    check(rd_en == 1'b0, tag, "rd_en while quiet", int'(rd_en), 0);
  endtask

  task automatic do_reset(input int len, input bit seg);
    @(negedge clk);
    rst = 1'b1;
    cfg_burst_len = LEN_W'(len);
    cfg_segment = seg;
    idle(2);
    check(!rd_en && !burst_start && !burst_end, "R1", "outputs in reset",
          int'({rd_en, burst_start, burst_end}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!rd_en && !burst_start && !burst_end, "R1", "outputs after reset",
          int'({rd_en, burst_start, burst_end}), 0);
  endtask

  // Monitor / scoreboard
  bit in_b = 1'b0;
  bit prev_rd = 1'b0;
  int cnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_en) begin
        if (burst_start) begin
          check(!prev_rd, "R9", "start right after a burst", int'(prev_rd), 0);
          in_b = 1'b1;
          cnt = 0;
        end else if (!in_b) begin
          check(1'b0, "R2", "rd_en outside a burst", 1, 0);
        end
        cnt++;
        if (burst_end) begin
          if (exp_len.size() == 0) begin
            check(1'b0, "R7", "unexpected burst length", cnt, 0);
          end else begin
            string t;
            int e;
            e = exp_len.pop_front();
            t = exp_tag.pop_front();
            check(cnt == e, t, "burst length", cnt, e);
          end
          in_b = 1'b0;
        end
      end else begin
        if (in_b) begin
          check(1'b0, "R2", "gap inside burst", 0, 1);
          in_b = 1'b0;
        end
        if (burst_start || burst_end)
          check(1'b0, "R2", "strobe without rd_en",
                int'({burst_start, burst_end}), 0);
      end
    end
    prev_rd = rd_en;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Test A: whole mode, cap 2, credits arrive one at a time
    do_reset(2, 1'b0);
    push_pkt(16, 1'b0);
    idle(30);
    check_quiet("R7");
    add_credit(1);
    idle(30);
    check_quiet("R3");
    expect_burst(16, "R3");
    add_credit(1);
    idle(40);
    check_quiet("R3");

    // Test B: whole mode waits for full data, then packet ends
    do_reset(2, 1'b0);
    add_credit(5);
    push_pkt(12, 1'b0);
    idle(30);
    check_quiet("R3");
    expect_burst(16, "R3");
    push_pkt(4, 1'b0);
    idle(40);
    expect_burst(5, "R4");
    push_pkt(5, 1'b1);
    idle(30);
    expect_burst(9, "R4");
    push_pkt(9, 1'b1);
    idle(30);
    push_pkt(3, 1'b1);
    idle(30);
    check_quiet("R7");
    expect_burst(3, "R4");
    add_credit(1);
    idle(30);
    check_quiet("R4");

    // Test C: segment mode, cap 4
    do_reset(4, 1'b1);
    add_credit(10);
    expect_burst(32, "R5");
    expect_burst(8, "R5");
    push_pkt(40, 1'b0);
    idle(80);
    expect_burst(20, "R6");
    push_pkt(20, 1'b1);
    idle(40);
    expect_burst(16, "R5");
    push_pkt(30, 1'b1);
    idle(40);
    check_quiet("R7");
    expect_burst(8, "R7");
    add_credit(1);
    idle(30);
    check_quiet("R7");
    expect_burst(6, "R6");
    add_credit(5);
    idle(30);
    check_quiet("R6");

    // Test D: cap 0 acts as 1 credit; one-word burst
    do_reset(0, 1'b0);
    add_credit(3);
    expect_burst(8, "R8");
    expect_burst(8, "R8");
    expect_burst(8, "R8");
    push_pkt(24, 1'b0);
    idle(60);
    check_quiet("R8");
    push_pkt(1, 1'b1);
    idle(20);
    check_quiet("R7");
    expect_burst(1, "R2");
    add_credit(1);
    idle(20);
    check_quiet("R2");

    // Test E: credit add lands on the burst planning cycle
    do_reset(2, 1'b1);
    add_credit(1);
    expect_burst(8, "R7");
    expect_burst(16, "R7");
    push_pkt(24, 1'b0);
    add_credit(3);
    idle(60);
    check_quiet("R7");
    expect_burst(8, "R7");
    push_pkt(16, 1'b0);
    idle(40);
    check_quiet("R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule